// File: doc/BRIEF.md
# Stereo Input Gain Control with Synchronized Commit

This block holds the gain settings for a two-channel programmable input amplifier. Software writes a 9-bit word to one of two register addresses, one address per channel. Each word carries a 6-bit gain code, a mute flag, a zero-cross enable and a one-shot update command. A gain code that has just been written is kept as a pending value. It reaches the channel's active output only when an update command arrives, and that command commits the pending codes of both channels in the same cycle.

A channel whose zero-cross enable is set does not apply its committed code at once. It holds the commit until its own signed sample stream next crosses zero, so the gain step lands where the waveform is near zero and produces little audible click. The mute flag bypasses this mechanism and takes effect on the next clock. Each channel reports its active code, its gain in signed quarter-dB steps, and its mute state. A read port returns the active settings for either address.

Top module: `stereo_pga_ctrl`

## Requirements
- R1: After reset, both active gain codes are 16 (0 dB), both quarter-dB outputs are 0, both mute outputs are 0, the zero-cross enables are 0, and a read of either channel address returns 0x010.
- R2: A write without the update bit loads the channel's pending code only, and the active gain output keeps its previous value.
- R3: A write with bit 8 set to either channel address commits the pending code of both channels. The value written in that same word counts as pending. A channel whose zero-cross enable is 0 shows the new code on its active output one clock after the write.
- R4: Address 45 selects the left channel and address 46 selects the right channel. In the data word, bits 5:0 are the gain code, bit 6 is mute (1 = muted), bit 7 is the zero-cross enable and bit 8 is the update command.
- R5: The mute bit appears on the channel's mute output one clock after the write and does not need an update command.
- R6: A channel whose zero-cross enable is 1 keeps its old active code after a commit. The code is applied one clock after the first valid sample of that channel that is zero, or whose sign bit differs from the channel's previous valid sample.
- R7: A further update command that arrives while a channel is still waiting for a crossing replaces the code that will be applied with the newest pending code.
- R8: The quarter-dB output equals 3 × code − 48 as a 9-bit two's-complement value. Code 0 gives −48, code 16 gives 0 and code 63 gives 141.
- R9: A read of a channel address returns {0, zero-cross enable, mute, active code} in bits 8..0. Bit 8 always reads 0, and any other address reads 0.
- R10: A zero crossing in the same cycle as an update command does not apply the new code. The channel keeps waiting for a later crossing. Samples on one channel never apply the other channel's code.
- R11: Writes to addresses other than 45 and 46 change no output and no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 6 | Write address |
| wr_data | input | 9 | Write data word |
| rd_addr | input | 6 | Read address |
| rd_data | output | 9 | Read data, combinational from rd_addr |
| smp_l | input | 16 | Left signed sample |
| smp_l_vld | input | 1 | Left sample valid |
| smp_r | input | 16 | Right signed sample |
| smp_r_vld | input | 1 | Right sample valid |
| gain_l | output | 6 | Left active gain code |
| gain_r | output | 6 | Right active gain code |
| qdb_l | output | 9 | Left gain in signed quarter-dB |
| qdb_r | output | 9 | Right gain in signed quarter-dB |
| mute_l | output | 1 | Left mute |
| mute_r | output | 1 | Right mute |

## Verification
The assertions assume that at most one write arrives per cycle and that sample strobes may coincide with writes. They also assume the inputs carry no X values once reset is released. The stimulus changes every input on the falling clock edge and holds it for one full cycle. Sample values are chosen so that the sign history before each commit is known. Only the one cycle in the coincidence test combines an update command with a crossing sample.

// File: rtl/pga_pkg.sv
package pga_pkg;
  localparam int unsigned CODE_W    = 6;
  localparam int unsigned DATA_W    = 9;
  localparam int unsigned QDB_W     = 9;
  localparam int unsigned MUTE_BIT  = CODE_W;
  localparam int unsigned ZCEN_BIT  = CODE_W + 1;
  localparam int unsigned UPD_BIT   = CODE_W + 2;
  localparam int unsigned CFG_W     = CODE_W + 2;
  localparam int unsigned ZERO_CODE = 16;
  localparam int unsigned STEP_QDB  = 3;
  localparam int unsigned CH_N      = 2;
endpackage

// File: rtl/pga_rst_sync.sv
module pga_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pga_zc_det.sv
module pga_zc_det #(
  parameter int unsigned SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] smp,
  input  logic             smp_vld,
  output logic             zc_o
);
  logic sign_q, seen_q;
  logic sign_d, seen_d;
  logic is_zero, sign_flip;

  assign is_zero   = (smp == '0);
  assign sign_flip = seen_q && (smp[SMP_W-1] != sign_q);
  assign zc_o      = smp_vld && (is_zero || sign_flip);

  always_comb begin
    sign_d = sign_q;
    seen_d = seen_q;
    if (smp_vld) begin
      sign_d = smp[SMP_W-1];
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (smp_vld) begin
      sign_q <= sign_d;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/pga_qdb.sv
module pga_qdb
  import pga_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [QDB_W-1:0]  qdb
);
  localparam logic [QDB_W-1:0] OFFSET = QDB_W'(STEP_QDB * ZERO_CODE);
  logic [QDB_W-1:0] ext;

  assign ext = {{(QDB_W-CODE_W){1'b0}}, code};
  assign qdb = (ext << 1) + ext - OFFSET;
endmodule

// File: rtl/pga_chan.sv
module pga_chan
  import pga_pkg::*;
#(
  parameter int unsigned SMP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [CFG_W-1:0]  wr_cfg,
  input  logic              upd,
  input  logic [SMP_W-1:0]  smp,
  input  logic              smp_vld,
  output logic [CODE_W-1:0] code_o,
  output logic [QDB_W-1:0]  qdb_o,
  output logic              mute_o,
  output logic              zcen_o
);
  localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(ZERO_CODE);

  logic [CODE_W-1:0] pend_q, pend_d;
  logic [CODE_W-1:0] act_q, act_d;
  logic [CODE_W-1:0] tgt_q, tgt_d;
  logic              hold_q, hold_d;
  logic              mute_q, mute_d;
  logic              zcen_q, zcen_d;
  logic              act_en, tgt_en, hold_en;
  logic              zc_hit;

  pga_zc_det #(.SMP_W(SMP_W)) u_zc (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp    (smp),
    .smp_vld(smp_vld),
    .zc_o   (zc_hit)
  );

  pga_qdb u_qdb (
    .code(act_q),
    .qdb (qdb_o)
  );

  // configuration next state
  always_comb begin
    pend_d = pend_q;
    mute_d = mute_q;
    zcen_d = zcen_q;
    if (wr_hit) begin
      pend_d = wr_cfg[CODE_W-1:0];
      mute_d = wr_cfg[MUTE_BIT];
      zcen_d = wr_cfg[ZCEN_BIT];
    end
  end

  // commit / deferred apply next state; update takes priority over a crossing
  always_comb begin
    act_d   = act_q;
    tgt_d   = tgt_q;
    hold_d  = hold_q;
    act_en  = 1'b0;
    tgt_en  = 1'b0;
    hold_en = 1'b0;
    if (upd) begin
      hold_en = 1'b1;
      if (zcen_d) begin
        tgt_en = 1'b1;
        tgt_d  = pend_d;
        hold_d = 1'b1;
      end else begin
        act_en = 1'b1;
        act_d  = pend_d;
        hold_d = 1'b0;
      end
    end else if (hold_q && zc_hit) begin
      act_en  = 1'b1;
      act_d   = tgt_q;
      hold_en = 1'b1;
      hold_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= RST_CODE;
      mute_q <= 1'b0;
      zcen_q <= 1'b0;
    end else if (wr_hit) begin
      pend_q <= pend_d;
      mute_q <= mute_d;
      zcen_q <= zcen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= RST_CODE;
    else if (act_en) act_q <= act_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_q <= RST_CODE;
    else if (tgt_en) tgt_q <= tgt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign code_o = act_q;
  assign mute_o = mute_q;
  assign zcen_o = zcen_q;

  // R2
  pend_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !upd && !hold_q) |=> $stable(code_o));

  // R3
  commit_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !zcen_d) |=> (code_o == $past(pend_d)));

  // R5
  mute_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (mute_o == $past(wr_cfg[MUTE_BIT])));

  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !upd && !zc_hit) |=> ($stable(code_o) && hold_q));

  // R8
  qdb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == RST_CODE) |-> (qdb_o == '0));
endmodule

// File: rtl/stereo_pga_ctrl.sv
module stereo_pga_ctrl
  import pga_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned SMP_W  = 16,
  parameter int unsigned ADDR_L = 45,
  parameter int unsigned ADDR_R = 46
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [SMP_W-1:0]  smp_l,
  input  logic              smp_l_vld,
  input  logic [SMP_W-1:0]  smp_r,
  input  logic              smp_r_vld,
  output logic [CODE_W-1:0] gain_l,
  output logic [CODE_W-1:0] gain_r,
  output logic [QDB_W-1:0]  qdb_l,
  output logic [QDB_W-1:0]  qdb_r,
  output logic              mute_l,
  output logic              mute_r
);
  localparam logic [ADDR_W-1:0] CH_ADDR [CH_N] = '{ADDR_W'(ADDR_L), ADDR_W'(ADDR_R)};

  logic              rst_n_s;
  logic [CH_N-1:0]   hit;
  logic              upd;
  logic [SMP_W-1:0]  smp_a   [CH_N];
  logic [CH_N-1:0]   vld_a;
  logic [CODE_W-1:0] code_a  [CH_N];
  logic [QDB_W-1:0]  qdb_a   [CH_N];
  logic [CH_N-1:0]   mute_a;
  logic [CH_N-1:0]   zcen_a;

  pga_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n_i(rst_n),
    .rst_n_o(rst_n_s)
  );

  assign smp_a[0] = smp_l;
  assign smp_a[1] = smp_r;
  assign vld_a    = {smp_r_vld, smp_l_vld};
  assign upd      = (|hit) && wr_data[UPD_BIT];

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    assign hit[ch] = wr_en && (wr_addr == CH_ADDR[ch]);

    pga_chan #(.SMP_W(SMP_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .wr_hit (hit[ch]),
      .wr_cfg (wr_data[CFG_W-1:0]),
      .upd    (upd),
      .smp    (smp_a[ch]),
      .smp_vld(vld_a[ch]),
      .code_o (code_a[ch]),
      .qdb_o  (qdb_a[ch]),
      .mute_o (mute_a[ch]),
      .zcen_o (zcen_a[ch])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int ch = 0; ch < CH_N; ch++) begin
      if (rd_addr == CH_ADDR[ch])
        rd_data = {1'b0, zcen_a[ch], mute_a[ch], code_a[ch]};
    end
  end

  assign gain_l = code_a[0];
  assign gain_r = code_a[1];
  assign qdb_l  = qdb_a[0];
  assign qdb_r  = qdb_a[1];
  assign mute_l = mute_a[0];
  assign mute_r = mute_a[1];

  // R9
  upd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_data[UPD_BIT] == 1'b0);

  // R4
  one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(hit));
endmodule

// File: tb/sim_stereo_pga_ctrl.sv
module sim_stereo_pga_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [5:0] wr_addr;
  logic [8:0] wr_data;
  logic [5:0] rd_addr;
  logic [8:0] rd_data;
  logic [15:0] smp_l, smp_r;
  logic       smp_l_vld, smp_r_vld;
  logic [5:0] gain_l, gain_r;
  logic [8:0] qdb_l, qdb_r;
  logic       mute_l, mute_r;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  stereo_pga_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .smp_l(smp_l), .smp_l_vld(smp_l_vld), .smp_r(smp_r), .smp_r_vld(smp_r_vld),
    .gain_l(gain_l), .gain_r(gain_r), .qdb_l(qdb_l), .qdb_r(qdb_r),
    .mute_l(mute_l), .mute_r(mute_r)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(addr); wr_data = 9'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic smp(input bit right, input int val);
    @(negedge clk);
    if (right) begin smp_r = 16'(val); smp_r_vld = 1'b1; end
    else       begin smp_l = 16'(val); smp_l_vld = 1'b1; end
    @(negedge clk);
    smp_l_vld = 1'b0; smp_r_vld = 1'b0;
  endtask

  task automatic rd(input string req, input int addr, input int exp);
    rd_addr = 6'(addr);
    #1;
    chk(req, int'(rd_data), exp);
  endtask

  function automatic int qdb_of(input int code);
    return 3 * code - 48;
  endfunction

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    smp_l = '0; smp_r = '0; smp_l_vld = 1'b0; smp_r_vld = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 gain_l", gain_l, 16);
    chk("R1 gain_r", gain_r, 16);
    chk("R1 qdb_l", int'($signed(qdb_l)), 0);
    chk("R1 qdb_r", int'($signed(qdb_r)), 0);
    chk("R1 mute_l", mute_l, 0);
    chk("R1 mute_r", mute_r, 0);
    rd("R1 read 45", 45, 16);
    rd("R1 read 46", 46, 16);

    // R2 R3 R4 R8 R9 full code sweep, committed from either address
    for (int c = 0; c < 64; c++) begin
      int prev_l, prev_r;
      prev_l = gain_l; prev_r = gain_r;
      if (c % 2 == 0) begin
        wr(45, c);
        chk("R2 left pending", gain_l, prev_l);
        wr(46, 9'h100 | (63 - c));
      end else begin
        wr(46, 63 - c);
        chk("R2 right pending", gain_r, prev_r);
        wr(45, 9'h100 | c);
      end
      chk("R3 gain_l commit", gain_l, c);
      chk("R3 gain_r commit", gain_r, 63 - c);
      chk("R8 qdb_l", int'($signed(qdb_l)), qdb_of(c));
      chk("R8 qdb_r", int'($signed(qdb_r)), qdb_of(63 - c));
      rd("R9 read 45", 45, c);
      rd("R9 read 46", 46, 63 - c);
    end
    // now left 63, right 0

    // R5 mute without update
    wr(45, 9'h040 | 63);
    chk("R5 mute_l set", mute_l, 1);
    chk("R5 mute_r untouched", mute_r, 0);
    chk("R5 gain_l held", gain_l, 63);
    rd("R9 read mute", 45, 9'h040 | 63);
    wr(46, 9'h040);
    chk("R5 mute_r set", mute_r, 1);
    wr(45, 63);
    chk("R5 mute_l clear", mute_l, 0);
    wr(46, 0);
    chk("R5 mute_r clear", mute_r, 0);

    // R11 other addresses ignored
    wr(44, 9'h1FF);
    wr(47, 9'h1C5);
    chk("R11 gain_l", gain_l, 63);
    chk("R11 gain_r", gain_r, 0);
    chk("R11 mute_l", mute_l, 0);
    chk("R11 mute_r", mute_r, 0);
    rd("R11 read 45", 45, 63);
    rd("R11 read 46", 46, 0);
    rd("R9 read other", 44, 0);

    // R6 deferred commit on left
    smp(1'b0, 50);
    wr(45, 9'h180 | 5);
    chk("R6 held after update", gain_l, 63);
    rd("R9 read zcen", 45, 9'h080 | 63);
    smp(1'b0, 100);
    chk("R6 same sign held", gain_l, 63);
    smp(1'b0, -5);
    chk("R6 applied on sign change", gain_l, 5);
    chk("R8 qdb after apply", int'($signed(qdb_l)), qdb_of(5));
    chk("R6 right untouched", gain_r, 0);

    // R7 retarget while waiting
    wr(45, 9'h180 | 7);
    smp(1'b0, -3);
    chk("R7 held", gain_l, 5);
    wr(45, 9'h180 | 9);
    chk("R7 still held", gain_l, 5);
    smp(1'b0, 0);
    chk("R7 newest code applied on zero", gain_l, 9);

    // R10 coincident crossing ignored, cross-channel isolation
    wr(46, 9'h080);
    smp(1'b1, 10);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'd46; wr_data = 9'h180 | 20;
    smp_r = 16'(-10); smp_r_vld = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; smp_r_vld = 1'b0;
    chk("R10 coincident crossing ignored", gain_r, 0);
    smp(1'b0, 40);
    smp(1'b0, -40);
    chk("R10 left samples do not apply right", gain_r, 0);
    chk("R10 left code kept", gain_l, 9);
    smp(1'b1, 1);
    chk("R10 later crossing applies", gain_r, 20);
    chk("R8 qdb_r", int'($signed(qdb_r)), qdb_of(20));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule